// File: doc/BRIEF.md
# Two-Context Switch-on-Miss Thread Controller

This controller lets one in-order, five-stage pipeline act as two virtual processors, each with its own program counter. One hardware context runs until it suffers a long-latency miss (a second-level cache miss). At that point the controller does four things:

- It issues a flush command.
- It stalls fetch for a fixed penalty while the pipeline empties.
- It saves the PC of the faulting instruction.
- It then redirects fetch to the other context at that context's saved PC.

A context whose miss is still outstanding is not eligible to run. If both contexts are waiting, the controller parks with fetch stalled until a miss-return arrives. Flushing the whole pipeline on every switch means no instruction from two different contexts is ever in flight at once, which keeps exception handling simple.

The pipeline reports its occupancy through one valid bit per stage. The cache hierarchy reports miss-returns through one bit per context. The pipeline datapath and the caches are outside this block.

Top module: `miss_switch_ctrl`

## Requirements
- R1: After reset, `active_tid` is 0, and `stall`, `flush` and `redirect_vld` are all low.
- R2: A `miss_valid` sampled while `stall` is low is accepted. In the next cycle `flush` is high for exactly one cycle and `stall` is high. `miss_pc` is saved as the restart PC of the context that was running.
- R3: After an accepted miss, `stall` stays high for exactly FLUSH_CYC (4) cycles when the pipeline is empty and the other context is not waiting. In the following cycle `redirect_vld` is high, `active_tid` is the other context, and `redirect_pc` is that context's saved PC.
- R4: If any `stage_valid` bit is set in the last penalty cycle, the stall is extended. The redirect comes one cycle after the first cycle in which `stage_valid` is zero.
- R5: If, at the end of the penalty, the other context is still waiting but the missing context's own miss has returned (in that cycle or earlier), fetch resumes the missing context at its faulting PC.
- R6: If both contexts are waiting at the end of the penalty, `stall` stays high. `redirect_vld` fires in the cycle after a `fill_done` bit arrives for a waiting context, and targets that context.
- R7: If both contexts' misses return in the same cycle while the controller is parked, the context other than the one that missed last is chosen.
- R8: `miss_valid` is ignored while `stall` is high. It starts no new penalty and changes no saved PC.
- R9: A `fill_done` bit (bit index = context ID) for a context that is not waiting has no effect.
- R10: `redirect_vld` is a single-cycle pulse, and `stall` is low in that cycle.
- R11: A context that has never missed starts from its reset PC (RESET_PC0 = 0x1000 for context 0, RESET_PC1 = 0x2000 for context 1). A context that did miss restarts from its faulting PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Long-latency miss from the running context |
| miss_pc | input | PC_W | PC of the faulting instruction |
| fill_done | input | 2 | Miss-return, one bit per context |
| stage_valid | input | STAGES | Per-stage valid bits of the pipeline |
| active_tid | output | 1 | Context currently owning the pipeline |
| flush | output | 1 | One-cycle flush command |
| stall | output | 1 | Fetch suppressed; nothing may be marked valid |
| redirect_vld | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | PC_W | Target PC of the redirect |

## Verification
The assertions check on every cycle the properties that involve no long window:

- A flush follows an accepted miss.
- A redirect is a lone pulse with stall low.
- A running context never has a pending miss.
- The parked state only occurs with both contexts waiting.
- The penalty timer is never restarted mid-count.

The remaining behaviour only shows up in the bench's scenarios against its cycle model:

- the exact length of the penalty and its extension while stages still hold valid instructions;
- which context is chosen when the misses overlap;
- the PC each context restarts from;
- that spurious or mistimed events are dropped.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_PARK  = 2'd2
  } ctl_state_e;

  typedef struct packed {
    logic go;
    logic tid;
  } pick_t;

  // Choose the next context: prefer the one that did not miss last.
  function automatic pick_t pick_next(input logic [1:0] pend, input logic cur);
    pick_t p;
    logic  o;
    o = ~cur;
    if (!pend[o]) begin
      p.go  = 1'b1;
      p.tid = o;
    end else if (!pend[cur]) begin
      p.go  = 1'b1;
      p.tid = cur;
    end else begin
      p.go  = 1'b0;
      p.tid = cur;
    end
    return p;
  endfunction

  // Clear returned misses, then mark a newly missing context.
  function automatic logic [1:0] pend_update(input logic [1:0] pend,
                                             input logic [1:0] fill,
                                             input logic       set_en,
                                             input logic       set_tid);
    logic [1:0] n;
    n = pend & ~fill;
    if (set_en) n[set_tid] = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/tsw_penalty_timer.sv
module tsw_penalty_timer #(
  parameter int FLUSH_CYC = 4,
  localparam int CNT_W = (FLUSH_CYC < 2) ? 1 : $clog2(FLUSH_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy,
  output logic expired,
  output logic done
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign expired = active_q && (cnt_q == '0);
  assign done    = expired && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(FLUSH_CYC - 1);
    end else if (active_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (!busy)  active_q <= 1'b0;
    end
  end

  // R8: a penalty is never restarted while one is counting
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active_q);

  // R4: once expired, the timer stays expired while stages are busy
  p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && busy && !start) |=> expired);
endmodule

// File: rtl/tsw_context_store.sv
module tsw_context_store #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC0 = 32'h0000_1000,
  parameter logic [PC_W-1:0] RESET_PC1 = 32'h0000_2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_en,
  input  logic            save_tid,
  input  logic [PC_W-1:0] save_pc,
  input  logic [1:0]      fill,
  input  logic            rd_tid,
  output logic [PC_W-1:0] rd_pc,
  output logic [1:0]      pend
);
  import tsw_pkg::*;

  logic [1:0] pend_n;
  assign pend_n = pend_update(pend, fill, save_en, save_tid);

  for (genvar t = 0; t < 2; t++) begin : g_ctx
    localparam logic [PC_W-1:0] RST_PC = (t == 0) ? RESET_PC0 : RESET_PC1;
    logic [PC_W-1:0] pc_r;
    logic            pend_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_r   <= RST_PC;
        pend_r <= 1'b0;
      end else begin
        if (save_en && (save_tid == 1'(t))) pc_r <= save_pc;
        pend_r <= pend_n[t];
      end
    end
    assign pend[t] = pend_r;
  end

  assign rd_pc = rd_tid ? g_ctx[1].pc_r : g_ctx[0].pc_r;

  // R2: the running context never has a pending miss when it faults
  p_save_not_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |-> !pend[save_tid]);

  // R9: a fill for a context that is not waiting leaves it not waiting
  p_spurious_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend[0] && !(save_en && !save_tid)) |=> !pend[0]);
endmodule

// File: rtl/miss_switch_ctrl.sv
module miss_switch_ctrl #(
  parameter int PC_W      = 32,
  parameter int STAGES    = 5,
  parameter int FLUSH_CYC = 4,
  parameter logic [PC_W-1:0] RESET_PC0 = 32'h0000_1000,
  parameter logic [PC_W-1:0] RESET_PC1 = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [PC_W-1:0]   miss_pc,
  input  logic [1:0]        fill_done,
  input  logic [STAGES-1:0] stage_valid,
  output logic              active_tid,
  output logic              flush,
  output logic              stall,
  output logic              redirect_vld,
  output logic [PC_W-1:0]   redirect_pc
);
  import tsw_pkg::*;

  ctl_state_e      state_q, state_n;
  logic            active_q, flush_q, rdr_vld_q;
  logic [PC_W-1:0] rdr_pc_q;

  // named internal events
  logic            accept_miss, timer_done, timer_expired, switch_go, park_go;
  logic [1:0]      pend, pend_eff;
  logic [PC_W-1:0] pick_pc;
  pick_t           pick;

  assign accept_miss = (state_q == ST_RUN) && miss_valid;
  assign pend_eff    = pend & ~fill_done;
  assign pick        = pick_next(pend_eff, active_q);
  assign switch_go   = ((state_q == ST_FLUSH) && timer_done && pick.go) ||
                       ((state_q == ST_PARK) && pick.go);
  assign park_go     = (state_q == ST_FLUSH) && timer_done && !pick.go;

  tsw_penalty_timer #(.FLUSH_CYC(FLUSH_CYC)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept_miss),
    .busy    (|stage_valid),
    .expired (timer_expired),
    .done    (timer_done)
  );

  tsw_context_store #(
    .PC_W(PC_W), .RESET_PC0(RESET_PC0), .RESET_PC1(RESET_PC1)
  ) i_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .save_en  (accept_miss),
    .save_tid (active_q),
    .save_pc  (miss_pc),
    .fill     (fill_done),
    .rd_tid   (pick.tid),
    .rd_pc    (pick_pc),
    .pend     (pend)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RUN:   if (accept_miss) state_n = ST_FLUSH;
      ST_FLUSH: if (switch_go) state_n = ST_RUN;
                else if (park_go) state_n = ST_PARK;
      ST_PARK:  if (switch_go) state_n = ST_RUN;
      default:  state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      active_q  <= 1'b0;
      flush_q   <= 1'b0;
      rdr_vld_q <= 1'b0;
      rdr_pc_q  <= '0;
    end else begin
      state_q   <= state_n;
      flush_q   <= accept_miss;
      rdr_vld_q <= switch_go;
      if (switch_go) begin
        active_q <= pick.tid;
        rdr_pc_q <= pick_pc;
      end
    end
  end

  assign active_tid   = active_q;
  assign flush        = flush_q;
  assign stall        = (state_q != ST_RUN);
  assign redirect_vld = rdr_vld_q;
  assign redirect_pc  = rdr_pc_q;

  // R2: an accepted miss flushes and stalls in the next cycle
  p_flush_follows_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_miss |=> (flush && stall));

  // R10: a redirect is unstalled and lasts one cycle
  p_redirect_unstalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> !stall);
  p_redirect_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |=> !redirect_vld);

  // R8: once stalled, only a switch ends the stall
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !switch_go) |=> stall);

  // R6: parking only happens with both contexts waiting
  p_park_both_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARK) |-> (pend == 2'b11));

  // R4: no switch out of the penalty before the timer has expired
  p_switch_after_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FLUSH) && switch_go) |-> timer_expired);
endmodule

// File: tb/test_miss_switch_ctrl.sv
module test_miss_switch_ctrl;
  localparam int PC_W = 32;
  localparam int STAGES = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              miss_valid = 1'b0;
  logic [PC_W-1:0]   miss_pc = '0;
  logic [1:0]        fill_done = '0;
  logic [STAGES-1:0] stage_valid = '0;
  logic              active_tid, flush, stall, redirect_vld;
  logic [PC_W-1:0]   redirect_pc;

  always #2 clk = ~clk;  // 250 MHz

  miss_switch_ctrl i_miss_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_pc(miss_pc),
    .fill_done(fill_done), .stage_valid(stage_valid), .active_tid(active_tid),
    .flush(flush), .stall(stall), .redirect_vld(redirect_vld),
    .redirect_pc(redirect_pc)
  );

  int n_chk = 0, n_fail = 0;

  // bench cycle model: mode 0 run, 1 penalty, 2 parked
  int              m_mode, m_cnt;
  logic            m_act, m_flush, m_rv;
  logic [1:0]      m_wait;
  logic [PC_W-1:0] m_pc [2];
  logic [PC_W-1:0] m_rpc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int choose(input logic [1:0] w, input logic cur);
    if (!w[!cur]) return int'(!cur);
    if (!w[cur]) return int'(cur);
    return -1;
  endfunction

  task automatic model_go(input logic [1:0] weff);
    int t;
    t = choose(weff, m_act);
    if (t < 0) m_mode = 2;
    else begin
      m_mode = 0; m_act = t[0]; m_rv = 1'b1; m_rpc = m_pc[t];
    end
  endtask

  task automatic step(input bit mv, input logic [PC_W-1:0] mpc,
                      input logic [1:0] fd, input logic [STAGES-1:0] sv,
                      input string tag);
    logic [1:0] weff;
    chk(stall === (m_mode != 0), tag, "stall", PC_W'(stall), PC_W'(m_mode != 0));
    chk(flush === m_flush, tag, "flush", PC_W'(flush), PC_W'(m_flush));
    chk(redirect_vld === m_rv, tag, "redirect_vld", PC_W'(redirect_vld), PC_W'(m_rv));
    if (m_rv) chk(redirect_pc === m_rpc, tag, "redirect_pc", redirect_pc, m_rpc);
    chk(active_tid === m_act, tag, "active_tid", PC_W'(active_tid), PC_W'(m_act));
    weff = m_wait & ~fd;
    m_flush = 1'b0; m_rv = 1'b0;
    case (m_mode)
      0: if (mv) begin
           weff[m_act] = 1'b1; m_pc[m_act] = mpc;
           m_mode = 1; m_cnt = 3; m_flush = 1'b1;
         end
      1: if (m_cnt != 0) m_cnt--;
         else if (sv == '0) model_go(weff);
      default: model_go(weff);
    endcase
    m_wait = weff;
    miss_valid = mv; miss_pc = mpc; fill_done = fd; stage_valid = sv;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, 2'b00, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_mode = 0; m_cnt = 0; m_act = 1'b0; m_flush = 1'b0; m_rv = 1'b0;
    m_wait = 2'b00; m_pc[0] = 32'h1000; m_pc[1] = 32'h2000; m_rpc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle(2, "R1");
    // R2, R3, R10, R11: t0 misses, switch to t1 at its reset PC
    step(1'b1, 32'h100, 2'b00, '0, "R2");
    idle(4, "R3");
    chk(redirect_pc === 32'h2000, "R11", "first pc of t1", redirect_pc, 32'h2000);
    idle(2, "R10");
    // R6: t1 misses while t0 waits -> park until a fill
    step(1'b1, 32'h204, 2'b00, '0, "R6");
    idle(8, "R6");
    chk(stall === 1'b1, "R6", "parked stall", PC_W'(stall), 1);
    step(1'b0, '0, 2'b01, '0, "R6");
    chk(redirect_pc === 32'h100, "R11", "t0 restart pc", redirect_pc, 32'h100);
    idle(2, "R11");
    // R5, R8: t0 misses, t1 still waits; own fill returns mid-penalty
    step(1'b1, 32'h300, 2'b00, '0, "R5");
    step(1'b1, 32'h999, 2'b00, '0, "R8");
    step(1'b0, '0, 2'b01, '0, "R5");
    idle(3, "R5");
    chk(redirect_pc === 32'h300, "R5", "resume own pc", redirect_pc, 32'h300);
    idle(1, "R5");
    // R4: t1 returns, t0 misses, stages stay busy past the penalty
    step(1'b0, '0, 2'b10, '0, "R9");
    step(1'b1, 32'h400, 2'b00, 5'b00100, "R4");
    for (int i = 0; i < 7; i++) step(1'b0, '0, 2'b00, 5'b00100, "R4");
    chk(stall === 1'b1, "R4", "stall extended", PC_W'(stall), 1);
    idle(3, "R4");
    // R7: t1 misses, both wait, both return together -> t0 chosen
    step(1'b1, 32'h500, 2'b00, '0, "R7");
    idle(6, "R7");
    step(1'b0, '0, 2'b11, '0, "R7");
    chk(active_tid === 1'b0, "R7", "tie pick", PC_W'(active_tid), 0);
    // R9: spurious fills on non-waiting contexts
    for (int i = 0; i < 4; i++) step(1'b0, '0, 2'b11, '0, "R9");
    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      bit mv;
      logic [1:0] fd;
      logic [STAGES-1:0] sv;
      mv = ($urandom % 6) == 0;
      fd = {($urandom % 8) == 0, ($urandom % 8) == 0};
      sv = (($urandom % 4) == 0) ? STAGES'($urandom) : '0;
      step(mv, $urandom & 32'hffff_fffc, fd, sv, "RND");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule